// File: doc/BRIEF.md
# Scanline Interrupt Counter Driven by Video Address Edges

This block watches the address bus on the video side of a system. When rendering, the video engine moves address bit 12 from low to high once per scanline. The block counts these rising edges and raises an interrupt request after a number of scanlines that software chooses. Software writes a reload value, arms or disarms the interrupt, and can force the counter to zero. The interrupt is a level line. It stays high until software acknowledges it.

The video fetch pattern can produce several bit-12 rises close together within one scanline. A rise therefore advances the counter only when the edge-filter countdown has reached zero. Every rise restarts that countdown. The countdown is measured in CPU ticks, which arrive as a clock enable on the system clock. A counter that sits at zero takes the reload value on its next qualified edge and does not decrement. The interrupt line presented to the CPU is refreshed only on CPU ticks.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the interrupt output is low, and the counter, reload value, enable, filter countdown and stored address are all zero.
- R2: A rising edge exists only on a cycle where `vbus_strobe` is high, `vbus_addr[12]` is 1, and bit 12 of the address held from the last strobed access is 0. Each strobed access stores its address. Address changes while the strobe is low are ignored.
- R3: A rising edge advances the counter only if the filter countdown is zero. Every rising edge, qualified or not, loads the countdown with `FILTER_TICKS` (default 6). The countdown drops by one on each `cpu_tick` while it is non-zero, and a load takes priority over a drop.
- R4: A qualified edge on a counter of zero loads the 8-bit reload value into the counter and does not raise the interrupt.
- R5: A qualified edge on a non-zero counter decrements it. If the result is zero while the enable is set, the internal interrupt flag is set.
- R6: With the enable clear, the counter still runs, but reaching zero does not set the flag.
- R7: Once set, the flag stays set until a pulse on `wr_irq_off`. That pulse clears both the flag and the enable. A pulse on `wr_irq_on` sets the enable and nothing else.
- R8: A pulse on `wr_clear` forces the counter to zero, so the next qualified edge reloads it.
- R9: `irq` takes the value of the internal flag only on clock edges where `cpu_tick` is high, and holds its value otherwise.
- R10: With a reload value of 0, every qualified edge leaves the counter at zero and the interrupt never rises. With a reload value of 1, the second qualified edge raises it.
- R11: In the same cycle, `wr_irq_off` wins over `wr_irq_on` and over a flag set, and `wr_clear` wins over a qualified edge. An edge reloads from the reload value held before a `wr_latch` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One-cycle enable per CPU cycle |
| vbus_addr | input | 14 | Video address bus |
| vbus_strobe | input | 1 | Marks a video read or write in this cycle |
| wr_latch | input | 1 | Write the reload value from `wr_data` |
| wr_data | input | 8 | Reload value data |
| wr_irq_on | input | 1 | Set the interrupt enable |
| wr_irq_off | input | 1 | Clear the enable and acknowledge the interrupt |
| wr_clear | input | 1 | Force the counter to zero |
| irq | output | 1 | Level interrupt request to the CPU |

## Verification
An access sampled at clock edge N changes the counter, the filter countdown and the internal flag at that same edge N. The `irq` output follows at the first edge after N on which `cpu_tick` is high, so it can lag by up to one tick period. Register writes behave the same way: acknowledge clears the flag at edge N and drops `irq` at the next tick edge. The bench model applies the same two-stage timing, with the update at the edge and the output change on a tick edge. It compares `irq` on every falling clock edge. Each directed check is taken only after an idle stretch longer than one tick period, so the output has settled.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_CLEAR  = 2'd1,
    CNT_RELOAD = 2'd2,
    CNT_STEP   = 2'd3
  } cnt_action_e;

  // Pick the counter action; clear outranks an edge (R8, R11)
  function automatic cnt_action_e pick_action(input logic clear,
                                              input logic qual,
                                              input logic at_zero);
    if (clear)        return CNT_CLEAR;
    else if (!qual)   return CNT_HOLD;
    else if (at_zero) return CNT_RELOAD;
    else              return CNT_STEP;
  endfunction

endpackage

// File: rtl/vbus_edge_detect.sv
module vbus_edge_detect #(
  parameter int ADDR_W   = 14,
  parameter int EDGE_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              rise
);
  logic [ADDR_W-1:0] last_addr;

  function automatic logic is_rise(input logic prev_bit, input logic cur_bit);
    return !prev_bit && cur_bit;
  endfunction

  assign rise = strobe && is_rise(last_addr[EDGE_BIT], addr[EDGE_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_addr <= '0;
    else if (strobe) last_addr <= addr;
  end

  // R2: each strobed access stores its address
  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> last_addr == $past(addr));
  // R2: an unstrobed cycle leaves the stored address untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(last_addr));
endmodule

// File: rtl/edge_filter.sv
module edge_filter #(
  parameter int FILTER_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rise,
  output logic qual
);
  localparam int FILT_W = $clog2(FILTER_TICKS + 1);
  localparam logic [FILT_W-1:0] FILT_LOAD = FILT_W'(FILTER_TICKS);

  logic [FILT_W-1:0] remain;
  logic              idle;

  function automatic logic [FILT_W-1:0] next_remain(input logic [FILT_W-1:0] cur,
                                                    input logic r,
                                                    input logic t);
    if (r)                   return FILT_LOAD;
    else if (t && cur != '0) return cur - 1'b1;
    else                     return cur;
  endfunction

  assign idle = (remain == '0);
  assign qual = rise && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else        remain <= next_remain(remain, rise, tick);
  end

  // R3: every rise restarts the window
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> remain == FILT_LOAD);
  // R3: ticks wear the window down by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && tick && !idle) |=> remain == $past(remain) - 1'b1);
  // R3: no change without a tick or a rise
  a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !tick) |=> $stable(remain));
endmodule

// File: rtl/line_counter.sv
module line_counter
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic             wr_clear,
  input  logic             wr_latch,
  input  logic [CNT_W-1:0] wr_data,
  output logic             hit
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  cnt_action_e      act;

  function automatic logic [CNT_W-1:0] next_count(input cnt_action_e a,
                                                  input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rl);
    case (a)
      CNT_CLEAR:  return '0;
      CNT_RELOAD: return rl;
      CNT_STEP:   return cur - 1'b1;
      default:    return cur;
    endcase
  endfunction

  assign act = pick_action(wr_clear, qual, count == '0);
  assign hit = (act == CNT_STEP) && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      count <= next_count(act, count, reload);
      if (wr_latch) reload <= wr_data;
    end
  end

  // R4: a qualified edge on zero takes the old reload value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !wr_clear && count == '0) |=> count == $past(reload));
  // R4: a reload never reports a hit
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !hit);
  // R8: clear forces zero
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> count == '0);
  // R5: a hit leaves the counter at zero
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> count == '0);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic wr_on,
  input  logic wr_off,
  output logic irq
);
  logic enable;
  logic flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      flag   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_off)     enable <= 1'b0;
      else if (wr_on) enable <= 1'b1;
      if (wr_off)             flag <= 1'b0;
      else if (hit && enable) flag <= 1'b1;
      if (tick) irq <= flag;
    end
  end

  // R5: an enabled hit sets the flag
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && enable && !wr_off) |=> flag);
  // R6: a disabled hit does not set it
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !enable) |=> !flag);
  // R7: the flag holds until acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_off) |=> flag);
  // R11: acknowledge wins
  a_r11_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> !flag && !enable);
  // R9: output only moves on ticks
  a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(irq));
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int ADDR_W       = 14,
  parameter int EDGE_BIT     = 12,
  parameter int CNT_W        = 8,
  parameter int FILTER_TICKS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic [ADDR_W-1:0] vbus_addr,
  input  logic              vbus_strobe,
  input  logic              wr_latch,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wr_irq_on,
  input  logic              wr_irq_off,
  input  logic              wr_clear,
  output logic              irq
);
  logic edge_rise;
  logic edge_qual;
  logic count_hit;

  vbus_edge_detect #(.ADDR_W(ADDR_W), .EDGE_BIT(EDGE_BIT)) u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(vbus_strobe), .addr(vbus_addr),
    .rise(edge_rise));

  edge_filter #(.FILTER_TICKS(FILTER_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(cpu_tick), .rise(edge_rise),
    .qual(edge_qual));

  line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .qual(edge_qual), .wr_clear(wr_clear),
    .wr_latch(wr_latch), .wr_data(wr_data), .hit(count_hit));

  irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .tick(cpu_tick), .hit(count_hit),
    .wr_on(wr_irq_on), .wr_off(wr_irq_off), .irq(irq));

  // R3: only a rise can qualify
  a_r3_qual_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    edge_qual |-> edge_rise);
  // R2: no edges without a strobe
  a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_strobe |-> !edge_rise);
endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_tick = 1'b0;
  logic [13:0] vbus_addr = 14'h0000;
  logic        vbus_strobe = 1'b0;
  logic        wr_latch = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_irq_on = 1'b0;
  logic        wr_irq_off = 1'b0;
  logic        wr_clear = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int tphase   = 0;
  bit finished = 0;

  // model state
  int m_last = 0, m_filt = 0, m_cnt = 0, m_lat = 0, m_en = 0, m_flag = 0, m_out = 0;

  always #10 clk = ~clk;

  scanline_irq_counter dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .vbus_addr(vbus_addr),
    .vbus_strobe(vbus_strobe), .wr_latch(wr_latch), .wr_data(wr_data),
    .wr_irq_on(wr_irq_on), .wr_irq_off(wr_irq_off), .wr_clear(wr_clear),
    .irq(irq));

  task automatic check(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_last = 0; m_filt = 0; m_cnt = 0; m_lat = 0; m_en = 0; m_flag = 0; m_out = 0;
    end else begin
      int rise, qual, hit, old_en, old_flag;
      rise = (vbus_strobe && m_last == 0 && vbus_addr[12]) ? 1 : 0;
      if (vbus_strobe) m_last = vbus_addr[12];
      qual = (rise && m_filt == 0) ? 1 : 0;
      if (rise) m_filt = 6;
      else if (cpu_tick && m_filt > 0) m_filt = m_filt - 1;
      old_en = m_en; old_flag = m_flag; hit = 0;
      if (wr_clear) m_cnt = 0;
      else if (qual) begin
        if (m_cnt == 0) m_cnt = m_lat;
        else begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) hit = 1;
        end
      end
      if (wr_latch) m_lat = wr_data;
      if (wr_irq_off) m_flag = 0;
      else if (hit && old_en) m_flag = 1;
      if (wr_irq_off) m_en = 0;
      else if (wr_irq_on) m_en = 1;
      if (cpu_tick) m_out = old_flag;
    end
  end

  // R9: output timing compared against the model every cycle
  always @(negedge clk) if (rst_n && !finished) check(irq, m_out, "R9 per-cycle");

  task automatic cyc(input logic s, input logic [13:0] a,
                     input logic wl = 0, input logic [7:0] d = 0,
                     input logic won = 0, input logic woff = 0, input logic wc = 0);
    @(negedge clk);
    vbus_strobe = s; vbus_addr = a;
    wr_latch = wl; wr_data = d; wr_irq_on = won; wr_irq_off = woff; wr_clear = wc;
    cpu_tick = (tphase == 11);
    tphase = (tphase == 11) ? 0 : tphase + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 14'h1000);
  endtask

  task automatic line(input int gap);
    cyc(1, 14'h0000);
    cyc(1, 14'h1000);
    idle(gap);
  endtask

  task automatic setup(input int latch_val, input logic enable);
    cyc(0, 14'h1000, 0, 0, 0, 1, 0);
    cyc(0, 14'h1000, 1, 8'(latch_val), enable, 0, 1);
    idle(30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check(irq, 0, "R1 reset");

    // R4/R5: latch 2, three spaced lines
    setup(2, 1);
    line(100); check(irq, 0, "R4 reload");
    line(100); check(irq, 0, "R5 step to one");
    line(100); check(irq, 1, "R5 reach zero");
    idle(200); check(irq, 1, "R7 hold");
    cyc(0, 14'h1000, 0, 0, 0, 1, 0); idle(30); check(irq, 0, "R7 acknowledge");

    // R3: close edges are filtered
    setup(2, 1);
    line(100);
    line(10);
    for (int k = 0; k < 5; k++) line(10);
    idle(100); check(irq, 0, "R3 filtered");
    line(100); check(irq, 1, "R3 spaced edge counts");

    // R2: unstrobed toggles and high-to-high accesses ignored; R10 latch 1
    setup(1, 1);
    line(100); check(irq, 0, "R10 reload one");
    for (int k = 0; k < 4; k++) begin
      cyc(0, 14'h0000); idle(100);
      cyc(0, 14'h1000); idle(100);
    end
    cyc(1, 14'h1000); idle(100);
    check(irq, 0, "R2 ignored");
    line(100); check(irq, 1, "R10 second edge");

    // R6: counter runs but disabled
    setup(1, 0);
    line(100); line(100); idle(50); check(irq, 0, "R6 masked");

    // R10: latch zero never fires
    setup(0, 1);
    for (int k = 0; k < 4; k++) line(100);
    check(irq, 0, "R10 latch zero");

    // R8: clear mid-count
    setup(3, 1);
    line(100); line(100);
    cyc(0, 14'h1000, 0, 0, 0, 0, 1); idle(20);
    line(100); check(irq, 0, "R8 reload after clear");
    line(100); line(100); check(irq, 0, "R8 count one");
    line(100); check(irq, 1, "R8 zero");

    // R11: acknowledge beats enable in the same cycle
    cyc(0, 14'h1000, 0, 0, 1, 1, 0); idle(30); check(irq, 0, "R11 off wins");
    // R11: clear beats a qualified edge
    setup(1, 1);
    line(100);
    cyc(1, 14'h0000);
    cyc(1, 14'h1000, 0, 0, 0, 0, 1); idle(100);
    check(irq, 0, "R11 clear wins");
    line(100); check(irq, 0, "R11 reload");
    line(100); check(irq, 1, "R11 fires after");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule